// File: doc/BRIEF.md
# SAR Converter Single-Shot Read Controller

This block is the host side of a small serial successive-approximation converter that has no chip select. One start line both frames the conversion and picks the input: a single high pulse picks the first channel (or unipolar mode on a differential part), while a short high-low preamble before the acquisition pulse picks the second channel (or bipolar mode). After the start line falls, the converter samples, converts on its own clock and then shifts its result out on a data line. The controller clocks the result in with a serial clock that idles low, keeps the ten code bits, drops the two trailing sub-bits and hands back a 16-bit word with a one-cycle valid strobe.

A request is a one-cycle `start_i` pulse with `sel_i` (input select) and `long_i` (16-clock frame instead of 12) sampled with it. Every window is a count of system clock cycles set by a parameter. The state machine walks IDLE, then PRE_HI and PRE_LO (only when `sel_i` is set), ACQ, CONV, then alternates CLK_LO and CLK_HI once per frame bit, then DONE, then back to IDLE. IDLE leaves on an accepted request, DONE always returns to IDLE after one cycle, CLK_HI goes to DONE after the last frame bit and back to CLK_LO otherwise, and every other state moves on when its window expires. With `DIFF_MODE` = 1, `sel_i` means bipolar and the code is sign-extended. With `DIFF_MODE` = 0, `sel_i` means channel 2 and the code is always zero-extended.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While and right after reset, `cnv_o`, `sclk_o`, `busy_o` and `valid_o` are low and `result_o` is 0.
- R2: A request with `sel_i` = 0 raises `cnv_o` in the cycle after the accepting edge and holds it high for exactly `ACQ_CYC` cycles, as a single pulse.
- R3: A request with `sel_i` = 1 produces `cnv_o` high for `PRE_HI_CYC` cycles, low for `PRE_LO_CYC` cycles, then high for `ACQ_CYC` cycles.
- R4: The first `sclk_o` rising edge comes exactly `CONV_CYC` + `SCLK_HALF` cycles after the final fall of `cnv_o`, and `sclk_o` stays low during the conversion wait.
- R5: `sclk_o` idles low, and every high phase and every low phase between rising edges lasts exactly `SCLK_HALF` cycles.
- R6: A frame has exactly 12 rising edges of `sclk_o` when `long_i` was 0 at the request, and exactly 16 when it was 1.
- R7: `sdata_i` is sampled on each `sclk_o` rising edge, MSB first. The first 10 samples form the code, and the two sub-bits and any later bits are dropped.
- R8: The code goes out in `result_o[9:0]`. Bits 15:10 copy bit 9 when `DIFF_MODE` = 1 and `sel_i` = 1 (two's complement), and are zero otherwise.
- R9: `busy_o` is high from the cycle after an accepted request until the end of the DONE cycle. A `start_i` pulse while `busy_o` is high is ignored and starts no later conversion.
- R10: `valid_o` is high for exactly one cycle, in the cycle after the last `sclk_o` high phase. `busy_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle conversion request, taken only when idle |
| sel_i | input | 1 | Input select: second channel, or bipolar mode |
| long_i | input | 1 | 1 selects a 16-clock frame, 0 a 12-clock frame |
| busy_o | output | 1 | A conversion is in progress |
| cnv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdata_i | input | 1 | Serial data from the converter |
| valid_o | output | 1 | One-cycle strobe, `result_o` is new |
| result_o | output | 16 | Extended 10-bit conversion code |

## Verification
The assertions assume that the converter changes `sdata_i` only after falling edges of `sclk_o` and of `cnv_o`, so each rising-edge sample sees a settled bit. They also assume that `start_i` is a clean synchronous pulse. The bench converter model updates its data line one time unit after the falling edge it reacts to, well clear of the next system clock edge. All requests and the one mid-conversion request are driven on falling system clock edges, so they meet the same setup on every run.

// File: rtl/sar_ctrl_pkg.sv
`timescale 1ns/1ps
package sar_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_ACQ,
        ST_CONV,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_DONE
    } sar_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_timer.sv
`timescale 1ns/1ps
module sar_timer #(
    parameter int unsigned TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] len_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_q;

    // a window of len_i cycles starts on the load edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sar_frame_rx.sv
`timescale 1ns/1ps
module sar_frame_rx #(
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned OUT_W     = 16,
    parameter int unsigned BCW       = 5,
    parameter bit          DIFF_MODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             cap_i,
    input  logic             sdata_i,
    input  logic             sel_i,
    output logic [BCW-1:0]   bits_o,
    output logic [OUT_W-1:0] word_o
);
    localparam logic [BCW-1:0] CODE_N = BCW'(CODE_W);
    localparam int unsigned    EXT_W  = OUT_W - CODE_W;

    logic [CODE_W-1:0] code_q;
    logic [BCW-1:0]    nb_q;
    logic              sext;

    // shift in MSB first; anything after the code bits is dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            nb_q   <= '0;
        end else if (clr_i) begin
            code_q <= '0;
            nb_q   <= '0;
        end else if (cap_i) begin
            if (nb_q < CODE_N)
                code_q <= {code_q[CODE_W-2:0], sdata_i};
            nb_q <= nb_q + 1'b1;
        end
    end

    generate
        if (DIFF_MODE) begin : g_diff
            assign sext = sel_i;
        end else begin : g_single
            assign sext = 1'b0;
        end
    endgenerate

    assign word_o = sext ? {{EXT_W{code_q[CODE_W-1]}}, code_q}
                         : {{EXT_W{1'b0}}, code_q};
    assign bits_o = nb_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int unsigned PRE_HI_CYC = 8,
    parameter int unsigned PRE_LO_CYC = 8,
    parameter int unsigned ACQ_CYC    = 350,
    parameter int unsigned CONV_CYC   = 925,
    parameter int unsigned SCLK_HALF  = 16,
    parameter int unsigned CODE_W     = 10,
    parameter int unsigned SUB_BITS   = 2,
    parameter int unsigned LONG_BITS  = 16,
    parameter int unsigned OUT_W      = 16,
    parameter bit          DIFF_MODE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sel_i,
    input  logic             long_i,
    output logic             busy_o,
    output logic             cnv_o,
    output logic             sclk_o,
    input  logic             sdata_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] result_o
);
    localparam int unsigned MAX_LEN = umax(umax(ACQ_CYC, CONV_CYC),
                                           umax(SCLK_HALF, umax(PRE_HI_CYC, PRE_LO_CYC)));
    localparam int unsigned TW      = $clog2(MAX_LEN + 1);
    localparam int unsigned BCW     = $clog2(LONG_BITS + 1);
    localparam logic [BCW-1:0] SHORT_N = BCW'(CODE_W + SUB_BITS);
    localparam logic [BCW-1:0] LONG_N  = BCW'(LONG_BITS);

    sar_state_e        state_q, state_nxt;
    logic              sel_q, long_q;
    logic [OUT_W-1:0]  result_q;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_len;
    logic              cap, clr;
    logic [BCW-1:0]    nbits;
    logic [BCW-1:0]    target;
    logic [OUT_W-1:0]  word;

    assign target = long_q ? LONG_N : SHORT_N;

    // next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_nxt = sel_i ? ST_PRE_HI : ST_ACQ;
            ST_PRE_HI: if (tmr_exp) state_nxt = ST_PRE_LO;
            ST_PRE_LO: if (tmr_exp) state_nxt = ST_ACQ;
            ST_ACQ:    if (tmr_exp) state_nxt = ST_CONV;
            ST_CONV:   if (tmr_exp) state_nxt = ST_CLK_LO;
            ST_CLK_LO: if (tmr_exp) state_nxt = ST_CLK_HI;
            ST_CLK_HI: if (tmr_exp) state_nxt = (nbits == target) ? ST_DONE : ST_CLK_LO;
            ST_DONE:   state_nxt = ST_IDLE;
        endcase
    end

    // window length of the state being entered
    always_comb begin
        case (state_nxt)
            ST_PRE_HI:            tmr_len = TW'(PRE_HI_CYC);
            ST_PRE_LO:            tmr_len = TW'(PRE_LO_CYC);
            ST_ACQ:               tmr_len = TW'(ACQ_CYC);
            ST_CONV:              tmr_len = TW'(CONV_CYC);
            ST_CLK_LO, ST_CLK_HI: tmr_len = TW'(SCLK_HALF);
            default:              tmr_len = TW'(1);
        endcase
    end

    assign tmr_load = (state_nxt != state_q);
    assign clr      = (state_q == ST_IDLE) && start_i;
    assign cap      = (state_q == ST_CLK_LO) && (state_nxt == ST_CLK_HI);

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sel_q    <= 1'b0;
            long_q   <= 1'b0;
            result_q <= '0;
        end else begin
            state_q <= state_nxt;
            if (clr) begin
                sel_q  <= sel_i;
                long_q <= long_i;
            end
            if ((state_q == ST_CLK_HI) && (state_nxt == ST_DONE))
                result_q <= word;
        end
    end

    // outputs decoded from the state
    always_comb begin
        cnv_o   = 1'b0;
        sclk_o  = 1'b0;
        busy_o  = 1'b1;
        valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o  = 1'b0;
            ST_PRE_HI: cnv_o   = 1'b1;
            ST_PRE_LO: cnv_o   = 1'b0;
            ST_ACQ:    cnv_o   = 1'b1;
            ST_CONV:   cnv_o   = 1'b0;
            ST_CLK_LO: sclk_o  = 1'b0;
            ST_CLK_HI: sclk_o  = 1'b1;
            ST_DONE:   valid_o = 1'b1;
        endcase
    end

    assign result_o = result_q;

    sar_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_exp)
    );

    sar_frame_rx #(
        .CODE_W    (CODE_W),
        .OUT_W     (OUT_W),
        .BCW       (BCW),
        .DIFF_MODE (DIFF_MODE)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .cap_i   (cap),
        .sdata_i (sdata_i),
        .sel_i   (sel_q),
        .bits_o  (nbits),
        .word_o  (word)
    );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
module sar_conv_ctrl_chk #(
    parameter int unsigned CONV_CYC  = 925,
    parameter int unsigned SCLK_HALF = 16,
    parameter int unsigned SHORT_N   = 12,
    parameter int unsigned LONG_N    = 16,
    parameter int unsigned OUT_W     = 16,
    parameter int unsigned CODE_W    = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             cnv_o,
    input logic             sclk_o,
    input logic             valid_o,
    input logic [OUT_W-1:0] result_o
);
    localparam int unsigned EXT_W = OUT_W - CODE_W;

    logic [31:0] hi_run, lo_run, cnv_lo;
    logic [7:0]  rises;
    logic        sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
            cnv_lo <= '0;
            rises  <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_o;
            hi_run <= sclk_o ? hi_run + 1 : '0;
            if (sclk_o)             lo_run <= '0;
            else if (lo_run != '1)  lo_run <= lo_run + 1;
            if (cnv_o)              cnv_lo <= '0;
            else if (cnv_lo != '1)  cnv_lo <= cnv_lo + 1;
            if (!busy_o)                rises <= '0;
            else if (sclk_o && !sclk_q) rises <= rises + 1'b1;
        end
    end

    // R4
    conv_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (cnv_lo >= 32'(CONV_CYC)));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> !sclk_o);

    // R5
    sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_run == 32'(SCLK_HALF)));

    // R5
    sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && (rises != 8'd0)) |-> (lo_run == 32'(SCLK_HALF)));

    // R6
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((rises == 8'(SHORT_N)) || (rises == 8'(LONG_N))));

    // R8
    ext_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (($countones(result_o[OUT_W-1:CODE_W]) == 0) ||
                     ($countones(result_o[OUT_W-1:CODE_W]) == EXT_W)));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !valid_o) |=> busy_o);

    // R10
    valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (!busy_o && !valid_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .CONV_CYC  (CONV_CYC),
    .SCLK_HALF (SCLK_HALF),
    .SHORT_N   (CODE_W + SUB_BITS),
    .LONG_N    (LONG_BITS),
    .OUT_W     (OUT_W),
    .CODE_W    (CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .cnv_o    (cnv_o),
    .sclk_o   (sclk_o),
    .valid_o  (valid_o),
    .result_o (result_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
    localparam int PRE_HI = 8;
    localparam int PRE_LO = 8;
    localparam int ACQ    = 350;
    localparam int CONV   = 925;
    localparam int HALF   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sel_i = 1'b0;
    logic        long_i = 1'b0;
    logic        busy_o, cnv_o, sclk_o, valid_o;
    logic        sdata_i = 1'b0;
    logic [15:0] result_o;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [11:0] mdl_frame = '0;
    int          mdl_idx = 0;

    always #2 clk = ~clk;

    sar_conv_ctrl #(
        .PRE_HI_CYC (PRE_HI),
        .PRE_LO_CYC (PRE_LO),
        .ACQ_CYC    (ACQ),
        .CONV_CYC   (CONV),
        .SCLK_HALF  (HALF),
        .DIFF_MODE  (1'b1)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sel_i    (sel_i),
        .long_i   (long_i),
        .busy_o   (busy_o),
        .cnv_o    (cnv_o),
        .sclk_o   (sclk_o),
        .sdata_i  (sdata_i),
        .valid_o  (valid_o),
        .result_o (result_o)
    );

    // converter model: data low while tracking, MSB after the sampling
    // edge, next bit after each serial clock fall, ones past the frame
    always @(posedge cnv_o) sdata_i <= #1 1'b0;
    always @(negedge cnv_o) begin
        mdl_idx = 0;
        sdata_i <= #1 mdl_frame[11];
    end
    always @(negedge sclk_o) begin
        mdl_idx = mdl_idx + 1;
        sdata_i <= #1 (mdl_idx < 12) ? mdl_frame[11 - mdl_idx] : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cnv_o && !sclk_o && !busy_o && !valid_o && result_o == 16'h0, "R1", "outputs in reset",
            {cnv_o, sclk_o, busy_o, valid_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cnv_o && !sclk_o && !busy_o && !valid_o && result_o == 16'h0, "R1", "outputs after reset",
            {cnv_o, sclk_o, busy_o, valid_o}, 0);
    endtask

    task automatic run_conv(input logic sel, input logic lng, input logic [9:0] code,
                            input logic [1:0] sub, input logic [15:0] exp_res, input bit poke);
        int seg[4];
        int nseg = 0, cur = 0, fall_idx = -1, first_rise = -1, rises = 0;
        int hmin = 99999, hmax = 0, lmin = 99999, lmax = 0, hrun = 0, lrun = 0;
        int exp_nseg = sel ? 3 : 1;
        logic last = 1'b0, sp = 1'b0;
        bit got = 0, busy_gap = 0, first_busy = 0;
        logic [15:0] res = '0;
        foreach (seg[k]) seg[k] = 0;

        mdl_frame = {code, sub};
        @(negedge clk);
        start_i = 1'b1; sel_i = sel; long_i = lng;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < 6000 && !got; c++) begin
            if (c > 0) @(negedge clk);
            if (poke && c == 200) start_i = 1'b1;
            if (poke && c == 201) start_i = 1'b0;
            if (c == 0) begin
                last = cnv_o; cur = 1; first_busy = busy_o;
            end else if (cnv_o == last) begin
                cur++;
            end else begin
                if (nseg < 4) seg[nseg] = cur;
                nseg++; cur = 1; last = cnv_o;
                if (nseg == exp_nseg && !cnv_o) fall_idx = c;
            end
            if (sclk_o && !sp) begin
                rises++;
                if (first_rise < 0) first_rise = c;
                if (rises > 1) begin
                    if (lrun < lmin) lmin = lrun;
                    if (lrun > lmax) lmax = lrun;
                end
                hrun = 1;
            end else if (sclk_o) begin
                hrun++;
            end
            if (!sclk_o && sp) begin
                if (hrun < hmin) hmin = hrun;
                if (hrun > hmax) hmax = hrun;
                lrun = 1;
            end else if (!sclk_o) begin
                lrun++;
            end
            sp = sclk_o;
            if (!busy_o) busy_gap = 1;
            if (valid_o) begin got = 1; res = result_o; end
        end

        chk(first_busy, "R9", "busy after accept", first_busy, 1);
        if (sel) begin
            chk(seg[0] == PRE_HI, "R3", "preamble high", seg[0], PRE_HI);
            chk(seg[1] == PRE_LO, "R3", "preamble low", seg[1], PRE_LO);
            chk(seg[2] == ACQ, "R3", "acquisition after preamble", seg[2], ACQ);
        end else begin
            chk(seg[0] == ACQ, "R2", "acquisition pulse", seg[0], ACQ);
        end
        chk(nseg == exp_nseg, "R2", "start line edges", nseg, exp_nseg);
        chk(first_rise - fall_idx == CONV + HALF, "R4", "fall to first rise",
            first_rise - fall_idx, CONV + HALF);
        chk(hmin == HALF && hmax == HALF, "R5", "high phase", hmax, HALF);
        chk(lmin == HALF && lmax == HALF, "R5", "low phase", lmax, HALF);
        chk(rises == (lng ? 16 : 12), "R6", "rising edges", rises, lng ? 16 : 12);
        chk(got && res == exp_res, "R7", "result word (R8 extension)", res, exp_res);
        chk(!busy_gap, "R9", "busy held to done", busy_gap, 0);
        @(negedge clk);
        chk(!valid_o && !busy_o, "R10", "valid one cycle then idle", {valid_o, busy_o}, 0);
        if (poke) begin
            bit moved = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (cnv_o || busy_o || sclk_o) moved = 1;
            end
            chk(!moved, "R9", "request during busy ignored", moved, 0);
        end
    endtask

    task automatic t_uni_short();
        run_conv(1'b0, 1'b0, 10'h2A5, 2'b11, 16'h02A5, 1'b0);
    endtask

    task automatic t_bip_negative();
        run_conv(1'b1, 1'b0, 10'h301, 2'b10, 16'hFF01, 1'b0);
    endtask

    task automatic t_bip_positive();
        run_conv(1'b1, 1'b0, 10'h0F0, 2'b01, 16'h00F0, 1'b0);
    endtask

    task automatic t_uni_long();
        run_conv(1'b0, 1'b1, 10'h3FF, 2'b00, 16'h03FF, 1'b0);
    endtask

    task automatic t_bip_long_busy();
        run_conv(1'b1, 1'b1, 10'h200, 2'b11, 16'hFE00, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_uni_short();
        t_bip_negative();
        t_bip_positive();
        t_uni_long();
        t_bip_long_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule